// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer run from the bus clock. A single-cycle `tick` strobe, arriving once per 10 ms, advances a 15-bit countdown. Software drives it through a small write port of 16-bit words at word-spaced byte offsets. The operations that matter for safety (restarting the count, turning the watchdog off or back on, and clearing the expired status) take effect only when an exact key word is written. Turning the watchdog off needs two different keys, written to two different registers one right after the other.

A maskable early-warning event is raised one tick before the count runs out. When the count expires, the block pulses `wdog_rst` for one clock, records a sticky expired status and starts the count again from the programmed timeout. An external debug-mode signal freezes the countdown unless software has set an override bit. Status reads return coded words rather than single flag bits.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the watchdog is disabled (offset 0x0C reads 0xDABE), the timeout register (0x04) reads 6000, the count is 6000, status (0x10) reads 0x0000, event (0x20) and mask (0x24) read 0, and `irq` and `wdog_rst` are low.
- R2: Writing 0xFEED to offset 0x00 reloads the count from the timeout register on that clock edge. Any other value written there leaves the count unchanged.
- R3: The timeout register at 0x04 keeps only bits [14:0] of a write. Bit 15 of a written word is dropped and reads back as 0.
- R4: The watchdog is disabled only by writing 0x2BAD to 0x08 and then 0xCAFE to 0x0C as the very next write to a key register (0x00, 0x08, 0x0C or 0x1C). Any other key-register write in between cancels the armed state. Writes to other offsets do not cancel it. Offset 0x0C reads 0x0000 while the watchdog is enabled.
- R5: Writing 0xACED to 0x1C enables the watchdog and reloads the count from the timeout register. Any other value written there is ignored.
- R6: While the watchdog is enabled, each advancing tick lowers the count by one. While it is disabled, the count holds its value. A reload in the same cycle as a tick takes priority over the tick.
- R7: An advancing tick when the count is 1 or 0 expires the watchdog. `wdog_rst` is high for exactly the next clock, and the count is reloaded from the timeout register.
- R8: After an expiry the status reads 0xCFE8. Only a write of 0xE8B4 to 0x10 returns it to 0x0000, and an expiry in the same cycle wins over the clear.
- R9: Offset 0x14 returns the count in bits [14:0]. Bit 15 is set for the single clock after any reload and is clear otherwise.
- R10: An advancing tick that takes the count from 2 to 1 sets event bit 0 (0x20). Writing a word with bit 0 set to 0x20 clears the event, and setting the event wins over clearing it.
- R11: `irq` is high exactly when event bit 0 and mask bit 0 (0x24, read/write) are both set.
- R12: Writing a word with bit 0 set to 0x28 sets the event. Offset 0x28 always reads 0.
- R13: Offset 0x18 reads `dbg_mode` in bit 1 and the override bit in bit 0. Bit 0 is writable. While `dbg_mode` is high and the override bit is 0, ticks do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe, once per 10 ms countdown unit |
| dbg_mode | input | 1 | High while the system is halted for debugging |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Early-warning interrupt |
| wdog_rst | output | 1 | One-clock reset request on expiry |

## Verification
A wrong armed state in the disable sequence shows at offset 0x0C on the clock after the 0xCAFE write: either a disable that should not have happened or one that was missed. A countdown that is off by one shows first as the warning event, and so `irq`, landing one tick early or late. It then shows as `wdog_rst` out of place on the following tick. Each of these is caught within one clock of the edge that caused it, because the bench's model checks `irq`, `wdog_rst` and the read data for the selected offset on every clock.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

  localparam int DW = 16;
  localparam int AW = 6;

  // register offsets (byte addresses, word spaced)
  localparam logic [AW-1:0] OFS_FEED   = 6'h00;
  localparam logic [AW-1:0] OFS_TMO    = 6'h04;
  localparam logic [AW-1:0] OFS_DIS1   = 6'h08;
  localparam logic [AW-1:0] OFS_DIS2   = 6'h0C;
  localparam logic [AW-1:0] OFS_STAT   = 6'h10;
  localparam logic [AW-1:0] OFS_CNT    = 6'h14;
  localparam logic [AW-1:0] OFS_DBG    = 6'h18;
  localparam logic [AW-1:0] OFS_RESUME = 6'h1C;
  localparam logic [AW-1:0] OFS_EVENT  = 6'h20;
  localparam logic [AW-1:0] OFS_MASK   = 6'h24;
  localparam logic [AW-1:0] OFS_FORCE  = 6'h28;

  // key words and coded read values
  localparam logic [DW-1:0] KEY_FEED     = 16'hFEED;
  localparam logic [DW-1:0] KEY_DIS1     = 16'h2BAD;
  localparam logic [DW-1:0] KEY_DIS2     = 16'hCAFE;
  localparam logic [DW-1:0] KEY_RESUME   = 16'hACED;
  localparam logic [DW-1:0] KEY_STCLR    = 16'hE8B4;
  localparam logic [DW-1:0] CODE_OFF     = 16'hDABE;
  localparam logic [DW-1:0] CODE_EXPIRED = 16'hCFE8;

  // decoded write actions
  typedef struct packed {
    logic feed;
    logic resume;
    logic kill;
    logic st_clr;
    logic ev_clr;
    logic ev_force;
  } wstrobe_t;

  // offsets whose writes take part in the disable sequence
  function automatic logic is_key_ofs(input logic [AW-1:0] a);
    return (a == OFS_FEED) || (a == OFS_DIS1) ||
           (a == OFS_DIS2) || (a == OFS_RESUME);
  endfunction

endpackage

// File: rtl/kwd_count.sv
module kwd_count
  import keyed_wdog_pkg::*;
#(
  parameter int CW          = 15,
  parameter int TIMEOUT_RST = 6000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          reload,
  input  logic [CW-1:0] timeout,
  output logic [CW-1:0] cnt,
  output logic          fresh,
  output logic          warn,
  output logic          expire,
  output logic          rst_pulse
);

  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  // value after an advancing tick: wrap to timeout at the end
  function automatic logic [CW-1:0] tick_next(input logic [CW-1:0] c,
                                              input logic [CW-1:0] t);
    return (c <= ONE) ? t : c - ONE;
  endfunction

  logic advance;

  always_comb begin
    advance = run && tick && !reload;
    expire  = advance && (cnt <= ONE);
    warn    = advance && (cnt == TWO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= CW'(TIMEOUT_RST);
      fresh     <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      if (reload)       cnt <= timeout;
      else if (advance) cnt <= tick_next(cnt, timeout);
      fresh     <= reload || expire;
      rst_pulse <= expire;
    end
  end

  // R6: no run and no reload keeps the count
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reload) |=> $stable(cnt));

  // R6: an advancing tick above one steps down by one
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !reload && cnt > ONE) |=> (cnt == $past(cnt) - ONE));

  // R7: expiry gives a reset pulse and a freshly reloaded count
  p_expire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !reload && cnt <= ONE) |=> (rst_pulse && fresh));

  // R9: the unstable flag only follows a reload or expiry
  p_fresh_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !expire) |=> !fresh);

endmodule

// File: rtl/kwd_irq.sv
module kwd_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic warn,
  input  logic ev_force,
  input  logic ev_clr,
  input  logic mask,
  output logic ev,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ev <= 1'b0;
    else if (warn || ev_force)  ev <= 1'b1;
    else if (ev_clr)            ev <= 1'b0;
  end

  assign irq = ev & mask;

  // R10: the warning sets the event
  p_warn_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    warn |=> ev);

  // R10: a clear without a set drops the event
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clr && !warn && !ev_force) |=> !ev);

  // R12: force sets the event
  p_force_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_force |=> ev);

endmodule

// File: rtl/kwd_regs.sv
module kwd_regs
  import keyed_wdog_pkg::*;
#(
  parameter int CW          = 15,
  parameter int TIMEOUT_RST = 6000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          expire,
  input  logic          dbg_mode,
  input  logic [CW-1:0] cnt,
  input  logic          fresh,
  input  logic          ev,
  output wstrobe_t      stb,
  output logic [CW-1:0] timeout,
  output logic          enabled,
  output logic          ovr,
  output logic          mask,
  output logic [DW-1:0] rdata
);

  logic armed;
  logic status_q;
  logic key_wr;

  always_comb begin
    key_wr       = wr && is_key_ofs(addr);
    stb.feed     = wr && (addr == OFS_FEED)   && (wdata == KEY_FEED);
    stb.resume   = wr && (addr == OFS_RESUME) && (wdata == KEY_RESUME);
    stb.kill     = wr && (addr == OFS_DIS2)   && (wdata == KEY_DIS2) && armed;
    stb.st_clr   = wr && (addr == OFS_STAT)   && (wdata == KEY_STCLR);
    stb.ev_clr   = wr && (addr == OFS_EVENT)  && wdata[0];
    stb.ev_force = wr && (addr == OFS_FORCE)  && wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      enabled  <= 1'b0;
      timeout  <= CW'(TIMEOUT_RST);
      status_q <= 1'b0;
      mask     <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      if (key_wr) armed <= (addr == OFS_DIS1) && (wdata == KEY_DIS1);
      if (stb.resume)    enabled <= 1'b1;
      else if (stb.kill) enabled <= 1'b0;
      if (expire)          status_q <= 1'b1;
      else if (stb.st_clr) status_q <= 1'b0;
      if (wr && addr == OFS_TMO)  timeout <= wdata[CW-1:0];
      if (wr && addr == OFS_MASK) mask    <= wdata[0];
      if (wr && addr == OFS_DBG)  ovr     <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_TMO:   rdata = DW'(timeout);
      OFS_DIS2:  rdata = enabled ? '0 : CODE_OFF;
      OFS_STAT:  rdata = status_q ? CODE_EXPIRED : '0;
      OFS_CNT:   rdata = DW'(cnt) | {fresh, {(DW-1){1'b0}}};
      OFS_DBG:   rdata = {{(DW-2){1'b0}}, dbg_mode, ovr};
      OFS_EVENT: rdata = {{(DW-1){1'b0}}, ev};
      OFS_MASK:  rdata = {{(DW-1){1'b0}}, mask};
      default:   rdata = '0;
    endcase
  end

  // R4: the watchdog turns off only from the armed state
  p_kill_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(enabled) |-> $past(armed));

  // R8: expiry records the status
  p_status_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> status_q);

  // R8: no expiry and no clear key leaves the status alone
  p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!expire && !stb.st_clr) |=> $stable(status_q));

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int CW          = 15,
  parameter int TIMEOUT_RST = 6000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          dbg_mode,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          wdog_rst
);

  wstrobe_t      stb;
  logic [CW-1:0] timeout;
  logic [CW-1:0] cnt;
  logic          enabled, ovr, mask, ev;
  logic          fresh, warn, expire;
  logic          run, reload;

  assign run    = enabled && (!dbg_mode || ovr);
  assign reload = stb.feed || stb.resume;

  kwd_regs #(.CW(CW), .TIMEOUT_RST(TIMEOUT_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .expire(expire), .dbg_mode(dbg_mode), .cnt(cnt), .fresh(fresh), .ev(ev),
    .stb(stb), .timeout(timeout), .enabled(enabled), .ovr(ovr), .mask(mask),
    .rdata(bus_rdata)
  );

  kwd_count #(.CW(CW), .TIMEOUT_RST(TIMEOUT_RST)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .reload(reload),
    .timeout(timeout), .cnt(cnt), .fresh(fresh), .warn(warn),
    .expire(expire), .rst_pulse(wdog_rst)
  );

  kwd_irq u_irq (
    .clk(clk), .rst_n(rst_n), .warn(warn), .ev_force(stb.ev_force),
    .ev_clr(stb.ev_clr), .mask(mask), .ev(ev), .irq(irq)
  );

  // R7: the reset request only ever lasts one clock while ticks are spaced
  p_rst_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_rst && !tick) |=> !wdog_rst);

endmodule

// File: tb/keyed_wdog_test.sv
`timescale 1ns/1ps
module keyed_wdog_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        dbg_mode = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = 6'h00;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic        irq, wdog_rst;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  keyed_wdog uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dbg_mode(dbg_mode),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .wdog_rst(wdog_rst)
  );

  // behavioural reference model
  int m_en = 0, m_arm = 0, m_tmo = 6000, m_cnt = 6000, m_fresh = 0;
  int m_stat = 0, m_ev = 0, m_mask = 0, m_ovr = 0, m_rst = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_arm = 0; m_tmo = 6000; m_cnt = 6000; m_fresh = 0;
      m_stat = 0; m_ev = 0; m_mask = 0; m_ovr = 0; m_rst = 0;
    end else begin
      int a, d, ld, adv, ex, wn, n_cnt;
      a = int'(bus_addr); d = int'(bus_wdata);
      ld = bus_wr && ((a == 0 && d == 'hFEED) || (a == 'h1C && d == 'hACED));
      adv = m_en && tick && (!dbg_mode || m_ovr) && !ld;
      ex = adv && (m_cnt <= 1);
      wn = adv && (m_cnt == 2);
      if (ld) n_cnt = m_tmo;
      else if (ex) n_cnt = m_tmo;
      else if (adv) n_cnt = m_cnt - 1;
      else n_cnt = m_cnt;
      if (wn || (bus_wr && a == 'h28 && d % 2 == 1)) m_ev = 1;
      else if (bus_wr && a == 'h20 && d % 2 == 1) m_ev = 0;
      if (ex) m_stat = 1;
      else if (bus_wr && a == 'h10 && d == 'hE8B4) m_stat = 0;
      if (bus_wr && a == 'h1C && d == 'hACED) m_en = 1;
      else if (bus_wr && a == 'h0C && d == 'hCAFE && m_arm) m_en = 0;
      if (bus_wr && (a == 0 || a == 8 || a == 'h0C || a == 'h1C))
        m_arm = (a == 8 && d == 'h2BAD);
      if (bus_wr && a == 4) m_tmo = d % 32768;
      if (bus_wr && a == 'h24) m_mask = d % 2;
      if (bus_wr && a == 'h18) m_ovr = d % 2;
      m_cnt = n_cnt;
      m_fresh = ld || ex;
      m_rst = ex;
    end
  end

  function automatic int model_read(input int a);
    case (a)
      'h04: return m_tmo;
      'h0C: return m_en ? 0 : 'hDABE;
      'h10: return m_stat ? 'hCFE8 : 0;
      'h14: return m_cnt + (m_fresh ? 'h8000 : 0);
      'h18: return (dbg_mode ? 2 : 0) + m_ovr;
      'h20: return m_ev;
      'h24: return m_mask;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #1;
      chk("R7 wdog_rst vs model", int'(wdog_rst), m_rst);
      chk("R11 irq vs model", int'(irq), (m_ev && m_mask) ? 1 : 0);
      chk("R9 rdata vs model", int'(bus_rdata), model_read(int'(bus_addr)));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic rd_now(input int a, input int exp, input string tag);
    bus_addr = 6'(a);
    #1;
    chk(tag, int'(bus_rdata), exp);
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk);
    rd_now(a, exp, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd('h0C, 'hDABE, "R1 disabled code");
    rd('h04, 6000, "R1 timeout");
    rd('h14, 6000, "R1 count");
    rd('h10, 0, "R1 status");
    rd('h20, 0, "R1 event");
    chk("R1 irq", int'(irq), 0);
    chk("R1 wdog_rst", int'(wdog_rst), 0);
    // R3 bit 15 dropped
    wr('h04, 'h8005);
    rd('h04, 5, "R3 timeout masked");
    // R6 frozen while disabled
    do_tick();
    rd('h14, 6000, "R6 frozen when disabled");
    // R5 wrong then right key
    wr('h1C, 'h1234);
    rd('h0C, 'hDABE, "R5 wrong resume ignored");
    wr('h1C, 'hACED);
    rd_now('h14, 'h8005, "R9 unstable after reload");
    rd('h14, 5, "R9 stable next clock");
    rd('h0C, 0, "R5 enabled code");
    // R6 countdown, R10 warning
    do_tick(); rd('h14, 4, "R6 step 4");
    do_tick(); do_tick(); rd('h14, 2, "R6 step 2");
    rd('h20, 0, "R10 no event yet");
    do_tick(); rd('h20, 1, "R10 event at one");
    chk("R11 masked irq low", int'(irq), 0);
    wr('h24, 1);
    rd_now('h24, 1, "R11 mask readback");
    chk("R11 irq high", int'(irq), 1);
    wr('h20, 1);
    rd_now('h20, 0, "R10 event cleared");
    chk("R11 irq low after clear", int'(irq), 0);
    // R7 expiry
    do_tick();
    #1 chk("R7 reset pulse", int'(wdog_rst), 1);
    @(negedge clk); #1 chk("R7 reset one clock", int'(wdog_rst), 0);
    rd('h14, 5, "R7 reload on expiry");
    rd('h10, 'hCFE8, "R8 expired code");
    // R8 clear key
    wr('h10, 'h1111); rd('h10, 'hCFE8, "R8 wrong key kept");
    wr('h10, 'hE8B4); rd('h10, 0, "R8 cleared");
    // R2 feed
    do_tick(); rd('h14, 4, "R6 step after expiry");
    wr('h00, 'hBEEF); rd('h14, 4, "R2 wrong feed ignored");
    wr('h00, 'hFEED);
    rd_now('h14, 'h8005, "R2 feed reload");
    // R4 disable sequence
    wr('h0C, 'hCAFE); rd('h0C, 0, "R4 second key alone");
    wr('h08, 'h2BAD); wr('h00, 0); wr('h0C, 'hCAFE);
    rd('h0C, 0, "R4 cancelled by key write");
    wr('h08, 'h2BAD); wr('h04, 5); wr('h0C, 'hCAFE);
    rd('h0C, 'hDABE, "R4 disabled");
    do_tick(); rd('h14, 5, "R6 frozen after disable");
    wr('h1C, 'hACED);
    // R13 debug freeze and override
    dbg_mode = 1'b1;
    rd('h18, 2, "R13 debug indicator");
    do_tick(); rd('h14, 5, "R13 frozen in debug");
    wr('h18, 1); rd('h18, 3, "R13 override set");
    do_tick(); rd('h14, 4, "R13 counts with override");
    dbg_mode = 1'b0;
    // R12 force
    wr('h28, 1);
    rd_now('h20, 1, "R12 forced event");
    rd('h28, 0, "R12 force reads zero");
    chk("R12 irq after force", int'(irq), 1);
    wr('h20, 1);
    rd('h20, 0, "R10 cleared after force");
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule